// File: doc/BRIEF.md
# TDM Channel PRBS Test Transmitter

This block puts a 2^15-1 pseudorandom test pattern into chosen timeslots of one serial TDM output stream. A frame has 32, 64 or 128 channels of eight bits, selected by a rate code for the 2.048, 4.096 and 8.192 Mb/s rates. Each frame lasts 125 µs. The block gets one strobe per serial bit, a frame pulse on the first bit of channel 0, and the number of the current channel. It also gets the connection-memory entry for that channel, which holds a mode bit and a 2-bit control field, plus a global transmit enable. It then chooses, bit by bit, whether the line carries the next pattern bit or the normal switched data bit.

A test burst is a run of one or more consecutive flagged channels. It can start anywhere in the frame and can fill the whole frame. The generator moves forward only on bits that carry the pattern, so the sequence runs on across the flagged channels of a burst and from one frame to the next. The enable is taken in at the start of each channel. While the enable is off, the generator is held at its seed, so the next test starts from the top of the sequence. The enable is off after reset.

Top module: `tdm_prbs_tx`

## Requirements
- R1: After reset, ser_o and prbs_o are 0 and the transmit enable is treated as off, so no channel carries the pattern until tx_en_i is seen high at a channel start.
- R2: A bit carries the pattern only when the enable in force is on, cm_mode_i is 1, and cm_ctl_i equals binary 10.
- R3: Every other combination of cm_mode_i and cm_ctl_i puts norm_bit_i on the line and sets prbs_o to 0.
- R4: The pattern comes from a 15-bit shift register with generator x^15 + x^14 + 1 and seed 15'h7FFF. Each pattern bit is register bit 14. After that bit is sent, the register shifts left and takes bit14 XOR bit13 into bit 0. The register is never all zeros.
- R5: The register steps only on bits that carry the pattern. Across non-flagged channels and across frame boundaries it keeps its state.
- R6: A channel number at or above the channel count never carries the pattern. The count is 32 for rate_i=0, 64 for rate_i=1, and 128 for rate_i=2 or 3.
- R7: tx_en_i is sampled on the first bit of each channel, and that value holds for the channel's eight bits. A change in the middle of a channel takes effect at the next channel start, so a disable is complete within one channel time.
- R8: While the enable in force is off, the register is reloaded with the seed, so a later burst starts again at the first sequence bit.
- R9: ser_o and prbs_o change only on the clock edge where bit_en_i is high. They show that bit's choice from that edge on and hold between strobes.
- R10: A bit strobe with frame_i high is treated as bit 0 of a channel, even when it comes in the middle of a channel, and sets the bit count again from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe per serial bit |
| frame_i | input | 1 | Frame start, valid together with bit_en_i |
| rate_i | input | 2 | Rate code: 0=32, 1=64, 2/3=128 channels |
| chan_i | input | CHAN_W | Current channel number |
| cm_mode_i | input | 1 | Message-mode bit of the channel's connection entry |
| cm_ctl_i | input | 2 | Per-channel control field; 10 selects the pattern |
| tx_en_i | input | 1 | Global transmit test enable |
| norm_bit_i | input | 1 | Switched data bit for the current slot |
| ser_o | output | 1 | Serial output bit |
| prbs_o | output | 1 | High when ser_o carries a pattern bit |

## Verification
The bench aims at bursts that run across several channels and frames. A generator that stepped on unflagged bits, or at frame boundaries, would send a pattern that diverges from the reference stream. The bench tries every near-miss encoding of the mode and control fields, so a decoder that looked at only one field would leak pattern bits. It flags channels past the rate's channel count and changes the enable in mid-channel, where a missing range check, or an enable that is not latched, would show up as the wrong bits. A frame pulse in mid-channel, sent together with a disable, shows whether the bit position is set again. A generator that was not reseeded while disabled would restart a burst at the wrong sequence bit.

// File: rtl/tdm_prbs_pkg.sv
package tdm_prbs_pkg;
  localparam logic [1:0] CTL_PRBS = 2'b10;

  function automatic int unsigned chan_count(input logic [1:0] rate);
    case (rate)
      2'd0:    return 32;
      2'd1:    return 64;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/tdm_prbs_lfsr.sv
module tdm_prbs_lfsr #(
  parameter int unsigned         W    = 15,
  parameter int unsigned         TAP  = 13,
  parameter logic [W-1:0]        SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic reload_i,
  output logic bit_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb    = state_q[W-1] ^ state_q[TAP];
  assign bit_o = state_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= SEED;
    else if (step_i)   state_q <= {state_q[W-2:0], fb};
    else if (reload_i) state_q <= SEED;
  end

  a_r4_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  a_r8_reseed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !step_i) |=> state_q == SEED);
  a_r5_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !reload_i) |=> $stable(state_q));
endmodule

// File: rtl/tdm_prbs_slot.sv
module tdm_prbs_slot #(
  parameter int unsigned BITS_PER_CHAN = 8,
  localparam int unsigned POS_W = $clog2(BITS_PER_CHAN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic frame_i,
  input  logic tx_en_i,
  output logic en_cur_o,
  output logic en_q_o
);
  logic [POS_W-1:0] pos_q, pos_cur;
  logic             en_q;

  // frame pulse forces bit 0 of a channel
  assign pos_cur  = frame_i ? '0 : pos_q;
  assign en_cur_o = (pos_cur == '0) ? tx_en_i : en_q;
  assign en_q_o   = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      en_q  <= 1'b0;
    end else if (bit_en_i) begin
      pos_q <= (pos_cur == POS_W'(BITS_PER_CHAN - 1)) ? '0 : pos_cur + 1'b1;
      en_q  <= en_cur_o;
    end
  end

  a_r10_frame_realign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && frame_i) |=> pos_q == POS_W'(1));
  a_r7_latch_mid_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !frame_i && pos_q != '0) |=> $stable(en_q));
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(en_q) && $stable(pos_q)));
endmodule

// File: rtl/tdm_prbs_tx.sv
module tdm_prbs_tx
  import tdm_prbs_pkg::*;
#(
  parameter int unsigned CHAN_W        = 7,
  parameter int unsigned BITS_PER_CHAN = 8,
  parameter int unsigned LFSR_W        = 15,
  parameter int unsigned LFSR_TAP      = 13,
  parameter logic [LFSR_W-1:0] SEED    = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              frame_i,
  input  logic [1:0]        rate_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              cm_mode_i,
  input  logic [1:0]        cm_ctl_i,
  input  logic              tx_en_i,
  input  logic              norm_bit_i,
  output logic              ser_o,
  output logic              prbs_o
);
  logic en_cur, en_q, in_range, flagged, active, prbs_bit;
  logic ser_q, prbs_q;

  tdm_prbs_slot #(.BITS_PER_CHAN(BITS_PER_CHAN)) u_slot (
    .clk_i, .rst_ni, .bit_en_i, .frame_i, .tx_en_i,
    .en_cur_o(en_cur), .en_q_o(en_q)
  );

  assign in_range = 32'(chan_i) < chan_count(rate_i);
  assign flagged  = cm_mode_i && (cm_ctl_i == CTL_PRBS);
  assign active   = en_cur && flagged && in_range;

  tdm_prbs_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP), .SEED(SEED)) u_lfsr (
    .clk_i, .rst_ni,
    .step_i  (bit_en_i && active),
    .reload_i(!en_q),
    .bit_o   (prbs_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q  <= 1'b0;
      prbs_q <= 1'b0;
    end else if (bit_en_i) begin
      ser_q  <= active ? prbs_bit : norm_bit_i;
      prbs_q <= active;
    end
  end

  assign ser_o  = ser_q;
  assign prbs_o = prbs_q;

  a_r9_hold_between_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(ser_o) && $stable(prbs_o)));
  a_r2_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !(cm_mode_i && cm_ctl_i == 2'b10)) |=> !prbs_o);
  a_r3_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !cm_mode_i) |=> ser_o == $past(norm_bit_i));
  a_r6_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && rate_i == 2'd0 && 32'(chan_i) >= 32) |=> !prbs_o);
endmodule

// File: tb/tdm_prbs_tx_test.sv
module tdm_prbs_tx_test;
  logic clk = 0, rst_n = 0;
  logic bit_en = 0, frame = 0, cm_mode = 0, tx_en = 0, norm_bit = 0;
  logic [1:0] rate = 0, cm_ctl = 0;
  logic [6:0] chan = 0;
  logic ser, prbs;

  int total = 0, bad = 0;
  logic       mem_mode [128];
  logic [1:0] mem_ctl  [128];

  // reference model state
  logic [14:0] m_lfsr = 15'h7FFF;
  logic        m_en = 0;
  int          m_pos = 0;
  logic        exp_ser = 0, exp_prbs = 0;

  tdm_prbs_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .frame_i(frame),
    .rate_i(rate), .chan_i(chan), .cm_mode_i(cm_mode), .cm_ctl_i(cm_ctl),
    .tx_en_i(tx_en), .norm_bit_i(norm_bit), .ser_o(ser), .prbs_o(prbs)
  );

  always #5 clk = ~clk;

  initial begin
    #1_900_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int nch(input logic [1:0] r);
    return (r == 0) ? 32 : (r == 1) ? 64 : 128;
  endfunction

  function automatic logic [14:0] lfsr_next(input logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  task automatic check(input string tag, input logic a_s, input logic a_p);
    total++;
    if (a_s !== exp_ser || a_p !== exp_prbs) begin
      bad++;
      $display("FAIL %s: actual ser=%b prbs=%b expected ser=%b prbs=%b",
               tag, a_s, a_p, exp_ser, exp_prbs);
    end
  endtask

  // one serial bit plus gap idle cycles; inputs driven at negedge
  task automatic send_bit(input logic fr, input int ch, input logic en, input int gap);
    logic old_en, en_cur, fl, act, nb;
    int   cur_pos;
    string tag;
    nb       = 1'($urandom);
    frame    = fr;
    chan     = 7'(ch);
    cm_mode  = mem_mode[ch];
    cm_ctl   = mem_ctl[ch];
    tx_en    = en;
    norm_bit = nb;
    bit_en   = 1;
    old_en   = m_en;
    cur_pos  = fr ? 0 : m_pos;
    en_cur   = (cur_pos == 0) ? en : m_en;
    fl       = mem_mode[ch] && mem_ctl[ch] == 2'b10;
    act      = en_cur && fl && (ch < nch(rate));
    exp_prbs = act;
    exp_ser  = act ? m_lfsr[14] : nb;
    if (act)          tag = "R4/R5 pattern bit";
    else if (fl && ch >= nch(rate)) tag = "R6 out of range";
    else if (fl)      tag = "R7/R10 enable in force";
    else              tag = "R2/R3 pass through";
    if (act)          m_lfsr = lfsr_next(m_lfsr);
    else if (!old_en) m_lfsr = 15'h7FFF;
    m_en  = en_cur;
    m_pos = (cur_pos + 1) % 8;
    @(negedge clk);
    bit_en = 0; frame = 0;
    check(tag, ser, prbs);
    for (int i = 0; i < gap; i++) begin
      if (!m_en) m_lfsr = 15'h7FFF;  // R8 reload while off
      @(negedge clk);
      check("R9 hold between strobes", ser, prbs);
    end
  endtask

  task automatic run_frame(input int nch_lim, input logic en, input int toggle_pct);
    logic e;
    e = en;
    for (int c = 0; c < nch_lim; c++)
      for (int b = 0; b < 8; b++) begin
        if (toggle_pct > 0 && ($urandom % 100) < toggle_pct) e = ~e;
        send_bit(c == 0 && b == 0, c, e, 1 + ($urandom % 2));
      end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) begin mem_mode[i] = 0; mem_ctl[i] = 0; end
  endtask

  task automatic flag(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin mem_mode[i] = 1; mem_ctl[i] = 2'b10; end
  endtask

  initial begin
    void'($urandom(32'd1234));
    clear_mem();
    @(negedge clk); @(negedge clk);
    exp_ser = 0; exp_prbs = 0;
    check("R1 reset outputs", ser, prbs);
    rst_n = 1;
    @(negedge clk);
    // R1: flagged channel, enable never seen high yet -> normal data
    flag(0, 0);
    send_bit(1, 0, 0, 1);

    // R2/R3: burst 5..9 plus near-miss encodings around it
    clear_mem(); flag(5, 9);
    mem_mode[10] = 1; mem_ctl[10] = 2'b01;
    mem_mode[11] = 1; mem_ctl[11] = 2'b11;
    mem_mode[12] = 1; mem_ctl[12] = 2'b00;
    mem_mode[13] = 0; mem_ctl[13] = 2'b10;
    flag(20, 21);
    rate = 0;
    run_frame(32, 1, 0);
    run_frame(32, 1, 0);   // R5 sequence continues across frames

    // R6: rate 0 but channels up to 127 driven, some flagged past 31
    flag(30, 40); flag(100, 127);
    run_frame(128, 1, 0);

    // full-frame burst at rate 1, end of frame
    clear_mem(); flag(0, 63); rate = 1;
    run_frame(64, 1, 0);

    // R7: mid-channel enable toggles
    clear_mem(); flag(3, 20); rate = 2;
    run_frame(128, 1, 4);

    // R8: disable one frame, re-enable -> restart from seed
    run_frame(32, 0, 0);
    clear_mem(); flag(0, 3);
    run_frame(8, 1, 0);

    // R10: mid-channel frame pulse carrying a disable
    clear_mem(); flag(0, 2);
    send_bit(1, 0, 1, 1);
    send_bit(0, 0, 1, 1);
    send_bit(0, 0, 1, 1);
    send_bit(1, 0, 0, 1);
    send_bit(0, 0, 1, 1);

    // random traffic
    for (int f = 0; f < 6; f++) begin
      rate = 2'($urandom);
      for (int i = 0; i < 128; i++) begin
        mem_mode[i] = 1'($urandom);
        mem_ctl[i]  = ($urandom % 3 == 0) ? 2'($urandom) : 2'b10;
      end
      run_frame(nch(rate), 1, 2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule